// File: doc/BRIEF.md
# Enclave APIC-Page Access Classifier

This block sits beside the address path of a core that runs protected enclaves under hardware APIC virtualization. For every memory access it receives the physical page the access resolves to, the linear address, the access kind, whether the core is in enclave mode and whether an enclave instruction issued the access. It compares these with the APIC-access page and with the enclave's linear range, and decides what the access leads to. There are five outcomes: the access proceeds, it raises a page fault, it raises a general-protection fault with a zero error code, it forces an APIC-access VM exit, or it is redirected to the virtual-APIC page.

The outcome is registered. It appears as a one-hot vector one clock after the input strobe, together with an output valid. Address translation, delivery of the fault or exit, and the memory system all lie outside the block.

Access kind encoding on `acc_kind`: 0 is implicit (a cached physical address to a control structure, a thread control structure or a state-save area), 1 is explicit enclave, 2 is non-enclave, 3 is instruction fetch. Result bit positions on `res`: bit 0 proceed, bit 1 page fault, bit 2 general-protection fault, bit 3 APIC-access VM exit, bit 4 virtual-APIC redirect.

Top module: `apic_acc_classifier`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is 0 and `res` is 5'b00001 (proceed) until the first strobed access.
- R2: `res_valid` is high exactly in the cycle after `in_valid` is high. When `in_valid` is low, `res` keeps its previous value whatever the other inputs do.
- R3: With `apic_virt_en` at 0, every access of kinds 0, 1 and 2 yields proceed (bit 0), even if its page equals the APIC-access page.
- R4: An implicit access (kind 0) always yields proceed and is never compared against the APIC-access page.
- R5: An explicit enclave access (kind 1) whose page equals `apic_ppn` yields page fault (bit 1) when `apic_virt_en` is 1. On a miss it yields proceed.
- R6: A non-enclave access (kind 2) that hits the APIC-access page with `apic_virt_en` at 1 yields APIC-access VM exit (bit 3) when `encl_mode` or `encl_insn` is 1.
- R7: A non-enclave access (kind 2) that hits the APIC-access page with `apic_virt_en` at 1, `encl_mode` at 0 and `encl_insn` at 0 yields virtual-APIC redirect (bit 4).
- R8: A fetch (kind 3) made in enclave mode whose linear address is outside the enclave range yields general-protection fault (bit 2). This takes priority over any APIC-page hit and applies whatever `apic_virt_en` is.
- R9: The enclave range covers `rng_base` up to but not including `rng_base + rng_size`. The sum is formed one bit wider than the address, so it never wraps.
- R10: An in-range fetch in enclave mode is handled as an explicit enclave access (hit gives page fault). A fetch outside enclave mode is handled as a non-enclave access (hit gives redirect, or VM exit if `encl_insn` is 1).
- R11: `res` always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronously released upstream |
| in_valid | input | 1 | Access strobe |
| encl_mode | input | 1 | Core is executing inside an enclave |
| encl_insn | input | 1 | Access is issued by an enclave instruction |
| acc_kind | input | 2 | Access kind (0 implicit, 1 explicit enclave, 2 non-enclave, 3 fetch) |
| acc_ppn | input | PPN_W | Physical page number of the access |
| acc_la | input | LA_W | Linear address of the access |
| rng_base | input | LA_W | Enclave linear range base |
| rng_size | input | LA_W | Enclave linear range size |
| apic_ppn | input | PPN_W | APIC-access page number |
| apic_virt_en | input | 1 | APIC-access virtualization enable |
| res_valid | output | 1 | Result valid, one cycle after `in_valid` |
| res | output | 5 | One-hot outcome |

## Verification
The bench builds the block with `PPN_W` = 2 and `LA_W` = 4. With these widths, the first sweep covers every combination of access kind, enclave mode, enclave-instruction flag, enable, access page and APIC page, at linear addresses on both sides of each range edge. With a 4-bit address, a second sweep can try every base, size and address for enclave fetches. That includes ranges whose end lies past the top of the address space, which shows that the wide sum does not wrap.

// File: rtl/apicc_pkg.sv
package apicc_pkg;

  typedef enum logic [1:0] {
    ACC_IMPL   = 2'd0,
    ACC_EXPL   = 2'd1,
    ACC_NONENC = 2'd2,
    ACC_FETCH  = 2'd3
  } acc_kind_e;

  localparam int RES_W     = 5;
  localparam int RB_PROC   = 0;
  localparam int RB_PF     = 1;
  localparam int RB_GP     = 2;
  localparam int RB_VMEXIT = 3;
  localparam int RB_REDIR  = 4;

  localparam logic [RES_W-1:0] RES_PROC   = RES_W'(1) << RB_PROC;
  localparam logic [RES_W-1:0] RES_PF     = RES_W'(1) << RB_PF;
  localparam logic [RES_W-1:0] RES_GP     = RES_W'(1) << RB_GP;
  localparam logic [RES_W-1:0] RES_VMEXIT = RES_W'(1) << RB_VMEXIT;
  localparam logic [RES_W-1:0] RES_REDIR  = RES_W'(1) << RB_REDIR;

endpackage

// File: rtl/apicc_range_chk.sv
module apicc_range_chk #(
  parameter int LA_W = 48
) (
  input  logic [LA_W-1:0] la,
  input  logic [LA_W-1:0] base,
  input  logic [LA_W-1:0] size,
  output logic            in_rng
);
  localparam int EW = LA_W + 1;

  logic [EW-1:0] lim_ext;
  logic [EW-1:0] la_ext;

  always_comb begin
    lim_ext = {1'b0, base} + {1'b0, size};
    la_ext  = {1'b0, la};
    in_rng  = (la >= base) && (la_ext < lim_ext);
  end
endmodule

// File: rtl/apicc_page_cmp.sv
module apicc_page_cmp #(
  parameter int PPN_W = 40
) (
  input  logic [PPN_W-1:0] acc_ppn,
  input  logic [PPN_W-1:0] apic_ppn,
  output logic             hit
);
  logic [PPN_W-1:0] diff;

  for (genvar gi = 0; gi < PPN_W; gi++) begin : g_bit
    assign diff[gi] = acc_ppn[gi] ^ apic_ppn[gi];
  end

  assign hit = ~|diff;
endmodule

// File: rtl/apicc_decide.sv
module apicc_decide
  import apicc_pkg::*;
(
  input  logic             encl_mode,
  input  logic             encl_insn,
  input  acc_kind_e        kind,
  input  logic             in_rng,
  input  logic             page_hit,
  input  logic             virt_en,
  output logic [RES_W-1:0] res_nxt
);
  logic fetch_escape;
  logic as_enclave;
  logic from_enclave;

  always_comb begin
    fetch_escape = (kind == ACC_FETCH) && encl_mode && !in_rng;
    as_enclave   = (kind == ACC_EXPL) || ((kind == ACC_FETCH) && encl_mode);
    from_enclave = encl_mode || encl_insn;

    res_nxt = RES_PROC;
    if (fetch_escape) begin
      res_nxt = RES_GP;
    end else if (virt_en && page_hit && (kind != ACC_IMPL)) begin
      if (as_enclave) begin
        res_nxt = RES_PF;
      end else if (from_enclave) begin
        res_nxt = RES_VMEXIT;
      end else begin
        res_nxt = RES_REDIR;
      end
    end
  end
endmodule

// File: rtl/apic_acc_classifier.sv
module apic_acc_classifier
  import apicc_pkg::*;
#(
  parameter int PPN_W = 40,
  parameter int LA_W  = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             encl_mode,
  input  logic             encl_insn,
  input  logic [1:0]       acc_kind,
  input  logic [PPN_W-1:0] acc_ppn,
  input  logic [LA_W-1:0]  acc_la,
  input  logic [LA_W-1:0]  rng_base,
  input  logic [LA_W-1:0]  rng_size,
  input  logic [PPN_W-1:0] apic_ppn,
  input  logic             apic_virt_en,
  output logic             res_valid,
  output logic [4:0]       res
);
  logic             in_rng;
  logic             page_hit;
  logic [RES_W-1:0] res_nxt;
  logic [RES_W-1:0] res_q;
  logic             vld_q;
  acc_kind_e        kind;

  assign kind = acc_kind_e'(acc_kind);

  apicc_range_chk #(.LA_W(LA_W)) i_rng (
    .la     (acc_la),
    .base   (rng_base),
    .size   (rng_size),
    .in_rng (in_rng)
  );

  apicc_page_cmp #(.PPN_W(PPN_W)) i_pg (
    .acc_ppn  (acc_ppn),
    .apic_ppn (apic_ppn),
    .hit      (page_hit)
  );

  apicc_decide i_dec (
    .encl_mode (encl_mode),
    .encl_insn (encl_insn),
    .kind      (kind),
    .in_rng    (in_rng),
    .page_hit  (page_hit),
    .virt_en   (apic_virt_en),
    .res_nxt   (res_nxt)
  );

  // rst_n is expected already synchronised on release by the reset tree
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= RES_PROC;
    end else if (in_valid) begin
      res_q <= res_nxt;
    end
  end

  assign res_valid = vld_q;
  assign res       = res_q;

  AST_RES_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(res) == 1); // R11

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid); // R2

  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid); // R2

  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res)); // R2

  AST_IMPL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_kind == 2'd0) |=> res[RB_PROC]); // R4

  AST_NOVIRT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !apic_virt_en && acc_kind != 2'd3) |=> res[RB_PROC]); // R3

  AST_PF_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_kind == 2'd2) |=> !res[RB_PF]); // R5

  AST_EXIT_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && acc_kind == 2'd1) |=> !res[RB_VMEXIT] && !res[RB_REDIR]); // R6

  AST_GP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && encl_mode && acc_kind == 2'd3 && !in_rng) |=> res[RB_GP]); // R8
endmodule

// File: tb/test_apic_acc_classifier.sv
module test_apic_acc_classifier;
  localparam int PW = 2;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          encl_mode;
  logic          encl_insn;
  logic [1:0]    acc_kind;
  logic [PW-1:0] acc_ppn;
  logic [AW-1:0] acc_la;
  logic [AW-1:0] rng_base;
  logic [AW-1:0] rng_size;
  logic [PW-1:0] apic_ppn;
  logic          apic_virt_en;
  logic          res_valid;
  logic [4:0]    res;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  apic_acc_classifier #(.PPN_W(PW), .LA_W(AW)) i_apic_acc_classifier (
    .clk, .rst_n, .in_valid, .encl_mode, .encl_insn, .acc_kind, .acc_ppn,
    .acc_la, .rng_base, .rng_size, .apic_ppn, .apic_virt_en, .res_valid, .res
  );

  function automatic logic [4:0] expect_res(int k, bit em, bit ei, bit ve,
                                            int pp, int ap, int la, int b, int s);
    bit inr = (la >= b) && (la < b + s);
    bit hit = (pp == ap);
    if (k == 3 && em && !inr) return 5'b00100;
    if (!ve || !hit || k == 0) return 5'b00001;
    if (k == 1 || (k == 3 && em)) return 5'b00010;
    if (em || ei) return 5'b01000;
    return 5'b10000;
  endfunction

  function automatic string tag_of(int k, bit em, bit ei, bit ve, bit hit, logic [4:0] e);
    if (e == 5'b00100) return "R8";
    if (!ve) return "R3";
    if (k == 0) return "R4";
    if (k == 3) return "R10";
    if (k == 1) return "R5";
    if (!hit) return "R5";
    if (em || ei) return "R6";
    return "R7";
  endfunction

  task automatic check(string tag, logic [4:0] got, logic [4:0] exp, logic gv, logic ev);
    total++;
    if (got !== exp || gv !== ev) begin
      bad++;
      $display("FAIL %s: res=%b valid=%b expected res=%b valid=%b", tag, got, gv, exp, ev);
    end
  endtask

  task automatic drive(int k, bit em, bit ei, bit ve, int pp, int ap, int la, int b, int s);
    in_valid     = 1'b1;
    acc_kind     = 2'(k);
    encl_mode    = em;
    encl_insn    = ei;
    apic_virt_en = ve;
    acc_ppn      = PW'(pp);
    apic_ppn     = PW'(ap);
    acc_la       = AW'(la);
    rng_base     = AW'(b);
    rng_size     = AW'(s);
  endtask

  task automatic run(string tag, int k, bit em, bit ei, bit ve, int pp, int ap,
                     int la, int b, int s);
    logic [4:0] e = expect_res(k, em, ei, ve, pp, ap, la, b, s);
    drive(k, em, ei, ve, pp, ap, la, b, s);
    @(negedge clk);
    check(tag, res, e, res_valid, 1'b1);
  endtask

  initial begin
    int las[4] = '{3, 4, 9, 10};
    rst_n = 1'b0;
    in_valid = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", res, 5'b00001, res_valid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", res, 5'b00001, res_valid, 1'b0);

    // Sweep A: all kinds and flags around range 4..9
    for (int k = 0; k < 4; k++)
      for (int em = 0; em < 2; em++)
        for (int ei = 0; ei < 2; ei++)
          for (int ve = 0; ve < 2; ve++)
            for (int pp = 0; pp < 4; pp++)
              for (int ap = 0; ap < 4; ap++)
                foreach (las[i]) begin
                  logic [4:0] e = expect_res(k, em[0], ei[0], ve[0], pp, ap, las[i], 4, 6);
                  run(tag_of(k, em[0], ei[0], ve[0], pp == ap, e),
                      k, em[0], ei[0], ve[0], pp, ap, las[i], 4, 6);
                end

    // R2: idle cycle with inputs that would give GP must not disturb result
    run("R6", 2, 1, 0, 1, 1, 1, 5, 4, 6);
    drive(3, 1, 0, 1, 0, 1, 0, 4, 6);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", res, 5'b01000, res_valid, 1'b0);
    @(negedge clk);
    check("R2", res, 5'b01000, res_valid, 1'b0);

    // Sweep B: enclave fetch, every base, size, address (R9 boundaries)
    for (int b = 0; b < 16; b++)
      for (int s = 0; s < 16; s++)
        for (int la = 0; la < 16; la++)
          run("R9", 3, 1, 0, 1, 0, 1, la, b, s);

    // R8: out-of-range fetch on APIC page with virtualization on and off
    run("R8", 3, 1, 0, 1, 2, 2, 15, 4, 6);
    run("R8", 3, 1, 1, 0, 2, 2, 0, 4, 6);

    in_valid = 1'b0;
    @(negedge clk);
    check("R2", res, 5'b00100, res_valid, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule